// File: doc/BRIEF.md
# GPIO Edge-Event Controller

A 32-line general-purpose I/O block attached to a plain register bus: byte address, write strobe, 32-bit write data and combinational 32-bit read data. Software picks per line whether it drives or listens, whether an output behaves push-pull or open-drain, and whether an input's pin level reaches the data register at all. Line n appears on register bit 31-n, so line 0 is the most significant bit of every register. The pin inputs are indexed by line: `pin_in[n]` is line n.

Every pin passes through a two-flop synchroniser. A registered copy of the last sample is kept, and each line's edge detector compares the two. A per-line edge-sense bit picks falling-only or both-edge detection. Each line owns a two-state event FSM: `EV_IDLE` moves to `EV_PENDING` on a detected edge (transition *capture*). `EV_PENDING` returns to `EV_IDLE` when software writes a one to that bit and no new edge arrives in the same cycle (transition *acknowledge*). A new edge in that cycle holds the bit (transition *re-arm*). Pending events that are also unmasked are ORed into one level interrupt.

A block-level settle FSM runs once after reset. It steps `SET_S1 -> SET_S2 -> SET_PREV -> SET_LIVE`, one state per clock. It holds edge detection off until the synchroniser and the previous-sample register both carry real pin levels, so lines that are already high at reset release do not raise events. It stays in `SET_LIVE` until the next reset.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `pin_oe` is all zero.
- R2: Register byte offsets: direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge-sense 0x14, input enable 0x18. Direction, open-drain, mask, edge-sense and input enable read back what was written. Any other address reads 0, and a write to it changes no register.
- R3: Line n is carried on register bit 31-n in every register; `pin_in`, `pin_out` and `pin_oe` are indexed by line.
- R4: For a line whose direction bit is 0 (input), the data register bit returns the synchronised pin when its input-enable bit is 1, and 0 when it is 0. The pin value shows in the readback two clock edges after it changes.
- R5: For a line whose direction bit is 1 (output), the data register bit returns the written output value regardless of the pin.
- R6: `pin_out[n]` equals the line's output data bit. `pin_oe[n]` is 1 only for an output line, and for an output line with open-drain bit 1 it is 1 only while the data bit is 0.
- R7: Edge-sense bit 0 captures both rising and falling edges; edge-sense bit 1 captures falling edges only. The event bit reads set three clock edges after the pin changes and not yet after two. Edges are detected whatever the line's direction and input enable.
- R8: Event bits are sticky: writing 1 to an event bit clears it, writing 0 leaves it unchanged, writing all ones clears every pending event.
- R9: When a new edge and a write of 1 hit the same event bit in the same cycle, the bit stays set.
- R10: `irq` is 1 exactly when some event bit and the matching mask bit are both 1 (mask bit 1 enables the line).
- R11: Pin levels present at reset release raise no event. Edge detection starts on the third clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pad input levels, bit n is line n |
| pin_out | output | 32 | Pad output levels, bit n is line n |
| pin_oe | output | 32 | Pad output enables, bit n is line n |
| irq | output | 1 | Level interrupt, pending and unmasked events |

## Verification
The hardest case to reach from the ports is a new edge landing in the same cycle as a software acknowledge of that line's event. The bench first leaves the bit pending. It then changes the pin and counts the two synchroniser edges. It places the event-register write so that its clock edge is the one on which the edge is captured, and expects the bit still set. The settle window is reached by holding several pins high through reset and reading the event register once the block is live.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    // register bus address width (byte addresses 0x00..0x1F)
    localparam int unsigned REG_AW = 5;

    typedef enum logic [REG_AW-1:0] {
        OFS_DIR = 5'h00,
        OFS_ODR = 5'h04,
        OFS_DAT = 5'h08,
        OFS_EVT = 5'h0C,
        OFS_MSK = 5'h10,
        OFS_EDG = 5'h14,
        OFS_IBE = 5'h18
    } reg_ofs_e;

    // block-level settle sequence after reset
    typedef enum logic [1:0] {
        SET_S1   = 2'd0,
        SET_S2   = 2'd1,
        SET_PREV = 2'd2,
        SET_LIVE = 2'd3
    } settle_e;

    // per-line event capture
    typedef enum logic {
        EV_IDLE    = 1'b0,
        EV_PENDING = 1'b1
    } ev_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] smp_q,
    output logic [W-1:0] prv_q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            smp_q  <= '0;
            prv_q  <= '0;
        end else begin
            meta_q <= async_in;
            smp_q  <= meta_q;
            prv_q  <= smp_q;
        end
    end

endmodule

// File: rtl/gpio_settle_fsm.sv
module gpio_settle_fsm
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic live
);

    settle_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SET_S1;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        live    = 1'b0;
        unique case (state_q)
            SET_S1:   state_d = SET_S2;
            SET_S2:   state_d = SET_PREV;
            SET_PREV: state_d = SET_LIVE;
            SET_LIVE: live    = 1'b1;
            default:  state_d = SET_S1;
        endcase
    end

endmodule

// File: rtl/gpio_event_cell.sv
module gpio_event_cell
    import gpio_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic smp,
    input  logic prv,
    input  logic fall_only,
    input  logic clr,
    output logic hit,
    output logic pending
);

    ev_state_e state_q, state_d;
    logic      changed;

    assign changed = live && (smp != prv);
    assign hit     = changed && (!fall_only || !smp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pending = 1'b0;
        unique case (state_q)
            EV_IDLE: begin
                if (hit) state_d = EV_PENDING;          // capture
            end
            EV_PENDING: begin
                pending = 1'b1;
                if (clr && !hit) state_d = EV_IDLE;     // acknowledge (re-arm otherwise)
            end
            default: state_d = EV_IDLE;
        endcase
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      smp_r,
    input  logic [W-1:0]      ev_r,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      odr_q,
    output logic [W-1:0]      dout_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      edge_q,
    output logic [W-1:0]      ibe_q,
    output logic [W-1:0]      ev_clr
);

    logic [W-1:0] dat_view;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            odr_q  <= '0;
            dout_q <= '0;
            mask_q <= '0;
            edge_q <= '0;
            ibe_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFS_DIR: dir_q  <= bus_wdata;
                OFS_ODR: odr_q  <= bus_wdata;
                OFS_DAT: dout_q <= bus_wdata;
                OFS_MSK: mask_q <= bus_wdata;
                OFS_EDG: edge_q <= bus_wdata;
                OFS_IBE: ibe_q  <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign ev_clr   = (bus_we && bus_addr == OFS_EVT) ? bus_wdata : '0;
    assign dat_view = (dir_q & dout_q) | (~dir_q & ibe_q & smp_r);

    always_comb begin
        case (bus_addr)
            OFS_DIR: bus_rdata = dir_q;
            OFS_ODR: bus_rdata = odr_q;
            OFS_DAT: bus_rdata = dat_view;
            OFS_EVT: bus_rdata = ev_r;
            OFS_MSK: bus_rdata = mask_q;
            OFS_EDG: bus_rdata = edge_q;
            OFS_IBE: bus_rdata = ibe_q;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int LINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);

    localparam int TOP = LINES - 1;

    // all vectors below are in register bit order (line n on bit TOP-n)
    logic [LINES-1:0] pin_r, smp_r, prv_r;
    logic [LINES-1:0] dir_q, odr_q, dout_q, mask_q, edge_q, ibe_q;
    logic [LINES-1:0] ev_clr, ev_q, hit_v, oe_reg, out_reg;
    logic             live;

    for (genvar n = 0; n < LINES; n++) begin : g_order
        assign pin_r[TOP-n] = pin_in[n];
        assign pin_out[n]   = out_reg[TOP-n];
        assign pin_oe[n]    = oe_reg[TOP-n];
    end

    gpio_sync #(.W(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_r),
        .smp_q    (smp_r),
        .prv_q    (prv_r)
    );

    gpio_settle_fsm u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .live  (live)
    );

    gpio_regs #(.W(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .smp_r     (smp_r),
        .ev_r      (ev_q),
        .dir_q     (dir_q),
        .odr_q     (odr_q),
        .dout_q    (dout_q),
        .mask_q    (mask_q),
        .edge_q    (edge_q),
        .ibe_q     (ibe_q),
        .ev_clr    (ev_clr)
    );

    for (genvar b = 0; b < LINES; b++) begin : g_evt
        gpio_event_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .live      (live),
            .smp       (smp_r[b]),
            .prv       (prv_r[b]),
            .fall_only (edge_q[b]),
            .clr       (ev_clr[b]),
            .hit       (hit_v[b]),
            .pending   (ev_q[b])
        );
    end

    // open-drain lines release the pad while their data bit is 1
    assign oe_reg  = dir_q & ~(odr_q & dout_q);
    assign out_reg = dout_q;
    assign irq     = |(ev_q & mask_q);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] bus_addr,
    input logic              bus_we,
    input logic [W-1:0]      bus_wdata,
    input logic              irq,
    input logic [W-1:0]      dir_q,
    input logic [W-1:0]      odr_q,
    input logic [W-1:0]      mask_q,
    input logic [W-1:0]      ev_q,
    input logic [W-1:0]      hit_v,
    input logic [W-1:0]      oe_reg,
    input logic [W-1:0]      out_reg,
    input logic              live
);

    logic evt_wr;
    assign evt_wr = bus_we && (bus_addr == OFS_EVT);

    // R6
    oe_only_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_reg & ~dir_q) == '0);

    // R6
    od_release_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_reg & odr_q & out_reg) == '0);

    // R8
    ev_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_wr |=> (($past(ev_q) & ~ev_q) == '0));

    // R8
    ev_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wr |=> ((ev_q & $past(bus_wdata) & ~$past(hit_v)) == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v != '0) |=> ((ev_q & $past(hit_v)) == $past(hit_v)));

    // R10
    irq_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R11
    settle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (ev_q == '0 && hit_v == '0));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.W(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .dir_q     (dir_q),
    .odr_q     (odr_q),
    .mask_q    (mask_q),
    .ev_q      (ev_q),
    .hit_v     (hit_v),
    .oe_reg    (oe_reg),
    .out_reg   (out_reg),
    .live      (live)
);

// File: tb/gpio_edge_ctrl_test.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_test;

    localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                           A_EVT = 5'h0C, A_MSK = 5'h10, A_EDG = 5'h14,
                           A_IBE = 5'h18, A_BAD = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gpio_edge_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [31:0] rb(input int line);
        return 32'(1) << (31 - line);
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, exp;
        // R11: pins high through reset
        pin_in = 32'hA5A5_0F0F;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        settle(6);

        // R1 reset state
        rd(A_DIR, d); check("R1 dir", d, 0);
        rd(A_ODR, d); check("R1 odr", d, 0);
        rd(A_DAT, d); check("R1 dat", d, 0);
        rd(A_MSK, d); check("R1 msk", d, 0);
        rd(A_EDG, d); check("R1 edg", d, 0);
        rd(A_IBE, d); check("R1 ibe", d, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 oe", pin_oe, 0);
        rd(A_EVT, d); check("R11 no event from reset levels", d, 0);

        pin_in = '0; settle(4);
        wr(A_EVT, '1);
        rd(A_EVT, d); check("R8 clear all", d, 0);

        // R2 readback and unmapped address
        wr(A_DIR, 32'h1357_9BDF); wr(A_ODR, 32'h2468_ACE0);
        wr(A_MSK, 32'h0F0F_00FF); wr(A_EDG, 32'hF0F0_FF00);
        wr(A_IBE, 32'h3C3C_C3C3); wr(A_BAD, 32'hFFFF_FFFF);
        rd(A_DIR, d); check("R2 dir", d, 32'h1357_9BDF);
        rd(A_ODR, d); check("R2 odr", d, 32'h2468_ACE0);
        rd(A_MSK, d); check("R2 msk", d, 32'h0F0F_00FF);
        rd(A_EDG, d); check("R2 edg", d, 32'hF0F0_FF00);
        rd(A_IBE, d); check("R2 ibe", d, 32'h3C3C_C3C3);
        rd(A_BAD, d); check("R2 unmapped", d, 0);
        rd(A_EVT, d); check("R2 unmapped write no event clear/set", d, 0);
        wr(A_DIR, 0); wr(A_ODR, 0); wr(A_MSK, 0); wr(A_EDG, 0); wr(A_IBE, 0);

        // R3/R4 input readback sweep
        for (int n = 0; n < 32; n++) begin
            wr(A_IBE, 0);
            pin_in = 32'(1) << n;
            settle(2);
            rd(A_DAT, d); check("R4 input gated off", d, 0);
            wr(A_IBE, rb(n));
            rd(A_DAT, d); check("R3 R4 input line bit", d, rb(n));
        end
        pin_in = '0; settle(3);
        wr(A_EVT, '1);

        // R5 output readback, mixed directions
        wr(A_IBE, '1);
        wr(A_DAT, 32'h1234_5678);
        wr(A_DIR, '1);
        pin_in = 32'hFFFF_FFFF; settle(3);
        rd(A_DAT, d); check("R5 all outputs", d, 32'h1234_5678);
        wr(A_DIR, 32'hFFFF_0000);
        pin_in = 32'h0000_A5C3; settle(3);
        exp = (32'h1234_5678 & 32'hFFFF_0000) | (~32'hFFFF_0000 & rev(32'h0000_A5C3));
        rd(A_DAT, d); check("R5 mixed", d, exp);
        pin_in = '0; settle(3);
        wr(A_DIR, 0); wr(A_IBE, 0); wr(A_DAT, 0); wr(A_EVT, '1);

        // R6 pad control sweep
        for (int n = 0; n < 32; n++) begin
            for (int c = 0; c < 8; c++) begin
                logic dr, od, dv, oe;
                dr = c[2]; od = c[1]; dv = c[0];
                wr(A_DIR, dr ? rb(n) : 0);
                wr(A_ODR, od ? rb(n) : 0);
                wr(A_DAT, dv ? rb(n) : 0);
                oe = dr & (~od | ~dv);
                check("R6 pin_oe", pin_oe, oe ? (32'(1) << n) : 0);
                check("R6 pin_out", pin_out, dv ? (32'(1) << n) : 0);
            end
        end
        wr(A_DIR, 0); wr(A_ODR, 0); wr(A_DAT, 0);

        // R7 edge sense sweep with latency
        for (int m = 0; m < 2; m++) begin
            wr(A_EDG, m ? '1 : 0);
            for (int n = 0; n < 32; n++) begin
                wr(A_EVT, '1);
                @(negedge clk); pin_in = 32'(1) << n;
                repeat (2) @(posedge clk); @(negedge clk);
                rd(A_EVT, d); check("R7 not yet after two edges", d, 0);
                @(posedge clk); @(negedge clk);
                rd(A_EVT, d); check("R7 rising", d, m ? 0 : rb(n));
                wr(A_EVT, '1);
                @(negedge clk); pin_in = '0;
                settle(3);
                rd(A_EVT, d); check("R7 falling", d, rb(n));
            end
        end
        wr(A_EDG, 0); wr(A_EVT, '1);

        // R10 interrupt mask sweep
        for (int n = 0; n < 32; n++) begin
            pin_in = 32'(1) << n; settle(3);
            pin_in = '0; settle(3);
            wr(A_MSK, rb(n));
            check("R10 unmasked irq", {31'd0, irq}, 1);
            wr(A_MSK, ~rb(n));
            check("R10 masked irq", {31'd0, irq}, 0);
            wr(A_EVT, rb(n));
            wr(A_MSK, '1);
            check("R10 cleared irq", {31'd0, irq}, 0);
        end
        wr(A_MSK, 0);

        // R8 sticky and write-one-to-clear
        pin_in = '1; settle(3);
        wr(A_EVT, 0);
        rd(A_EVT, d); check("R8 write zero keeps", d, 32'hFFFF_FFFF);
        wr(A_EVT, 32'h0000_FFFF);
        rd(A_EVT, d); check("R8 partial clear", d, 32'hFFFF_0000);
        settle(4);
        rd(A_EVT, d); check("R8 sticky without pin change", d, 32'hFFFF_0000);
        wr(A_EVT, '1);
        rd(A_EVT, d); check("R8 clear all", d, 0);
        pin_in = '0; settle(3);
        wr(A_EVT, '1);

        // R9 edge coinciding with clear on line 5
        @(negedge clk); pin_in = 32'(1) << 5;
        settle(3);
        rd(A_EVT, d); check("R9 pending before", d, rb(5));
        @(negedge clk); pin_in = '0;
        repeat (2) @(posedge clk);
        wr(A_EVT, rb(5));
        rd(A_EVT, d); check("R9 edge wins over clear", d, rb(5));
        wr(A_EVT, rb(5));
        rd(A_EVT, d); check("R9 later clear works", d, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule